// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Reset Sequencer

This block brings a PCIe root-port controller and its PHY out of reset in a fixed order. A `start` pulse begins the sequence. The block first holds the PHY in test power-down and keeps the reference clock gated. It then pulls the external endpoint reset low for a programmable number of ticks and releases it. After that it presents the static PHY configuration values and optionally raises a board power-on output. Next it lifts the power-down and enables the reference clock. The four functional clocks are then enabled one at a time, and each must report ready before the next is enabled.

All waits are counted in `tick` pulses rather than clock cycles, so one tick rate serves every wait. When all clocks are up, a settle window runs, and then the link-training enable is raised and `done` rises with `pass` set. If a clock fails to report ready within its timeout, the enables already granted are withdrawn one per cycle, highest first. In that case `done` rises with `pass` clear and link training stays disabled. A new `start` is accepted only while the block is idle or done.

Top module: `pcie_rst_seq`

## Requirements
- R1: After reset: phy_test_pd=1, ref_clk_en=0, ltssm_en=0, ep_rst_n=0, pwr_on=0, clk_en=0, done=0, pass=0 and every cfg_* output is 0.
- R2: The cycle after an accepted start: ltssm_en=1, phy_test_pd=1, ref_clk_en=0 and ep_rst_n=0. These values hold for exactly EP_RST_TICKS tick pulses, after which ep_rst_n goes to 1.
- R3: In the cycle ep_rst_n is released, ltssm_en falls to 0 and the cfg outputs take their constants until the next start: cfg_dev_type=4 (root port), cfg_los_lvl=9, cfg_deemph_g1=0, cfg_deemph_g2a=0, cfg_deemph_g2b=20, cfg_swing_full=127, cfg_swing_low=127. Before the release the cfg outputs are 0.
- R4: With PWR_ON_EN=1, pwr_on rises strictly before phy_test_pd falls; with PWR_ON_EN=0, pwr_on stays 0. phy_test_pd falls in the same cycle that ref_clk_en rises, and both happen before clk_en[0] rises.
- R5: clk_en bits rise in index order 0 to NCLK-1. Bit i+1 rises only after clk_rdy[i] has been seen high, and clk_en is always a contiguous mask from bit 0.
- R6: The timeout for clock i starts when clk_en[i] is raised. If RDY_TIMEOUT tick pulses are counted before clk_rdy[i] is seen high, the clock has failed. A ready seen on the same edge as the last counted tick still counts as success.
- R7: Once the last clock is ready, the block waits exactly SETTLE_TICKS tick pulses. It then raises ltssm_en, done=1 and pass=1, with all clk_en bits still set.
- R8: On a failure, clk_en bits are cleared one per cycle from the failed index down to 0. Then done=1 and pass=0 with clk_en=0 and ltssm_en=0.
- R9: start is ignored while a sequence is running. A start while done clears done, pass, clk_en and the cfg outputs and reruns the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted while idle or done) |
| tick | input | 1 | Time-base strobe; every wait counts these |
| clk_rdy | input | NCLK | Per-clock ready reports |
| phy_test_pd | output | 1 | PHY test power-down |
| ref_clk_en | output | 1 | Reference clock enable |
| ltssm_en | output | 1 | Link training enable |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| pwr_on | output | 1 | Optional endpoint power enable |
| clk_en | output | NCLK | Per-clock enables, bit 0 first |
| cfg_dev_type | output | 4 | Device type constant |
| cfg_los_lvl | output | 6 | Loss-of-signal level constant |
| cfg_deemph_g1 | output | 6 | Gen1 de-emphasis constant |
| cfg_deemph_g2a | output | 6 | Gen2 3.5 dB de-emphasis constant |
| cfg_deemph_g2b | output | 6 | Gen2 6 dB de-emphasis constant |
| cfg_swing_full | output | 7 | Full TX swing constant |
| cfg_swing_low | output | 7 | Low TX swing constant |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Sequence finished without a clock failure |

## Verification
The bench builds the block with NCLK=4, EP_RST_TICKS=5, SETTLE_TICKS=4 and RDY_TIMEOUT=3. A second copy with PWR_ON_EN=0 runs alongside the first. These short windows make it cheap to sweep tick spacings of one, two and three cycles against per-clock ready delays on both sides of the timeout boundary. The sweep reaches failure at the first clock, failure at the last clock, success on the final allowed tick, and start pulses during the reset pulse and during clock bring-up.

// File: rtl/prst_pkg.sv
package prst_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ENTRY,
      S_PHYCFG,
      S_PWRUP,
      S_REFON,
      S_CLKUP,
      S_SETTLE,
      S_UNWIND,
      S_DONE
   } prst_state_e;

   localparam logic [3:0] CFG_DEV_ROOT  = 4'd4;
   localparam logic [5:0] CFG_LOS       = 6'd9;
   localparam logic [5:0] CFG_DE_G1     = 6'd0;
   localparam logic [5:0] CFG_DE_G2A    = 6'd0;
   localparam logic [5:0] CFG_DE_G2B    = 6'd20;
   localparam logic [6:0] CFG_SW_FULL   = 7'd127;
   localparam logic [6:0] CFG_SW_LOW    = 7'd127;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prst_timer.sv
module prst_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          hit
);
   logic [TW-1:0] cnt;
   logic [TW:0]   cnt_p1;

   assign cnt_p1 = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
   assign hit    = tick && (cnt_p1 >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (tick && !hit)   cnt <= cnt_p1[TW-1:0];
   end
endmodule

// File: rtl/prst_clk_chain.sv
module prst_clk_chain #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set,
   input  logic [IW-1:0] set_idx,
   input  logic          drop,
   input  logic [IW-1:0] drop_idx,
   input  logic          drop_all,
   input  logic [IW-1:0] sel_idx,
   input  logic [N-1:0]  rdy,
   output logic [N-1:0]  en,
   output logic          rdy_sel
);
   for (genvar g = 0; g < N; g++) begin : g_en
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= 1'b0;
         else if (drop_all)                         q <= 1'b0;
         else if (set && (set_idx == IW'(g)))       q <= 1'b1;
         else if (drop && (drop_idx == IW'(g)))     q <= 1'b0;
      end
      assign en[g] = q;
   end

   always_comb begin
      rdy_sel = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (sel_idx == IW'(i)) rdy_sel = rdy[i];
      end
   end
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
   import prst_pkg::*;
#(
   parameter int NCLK         = 4,
   parameter int EP_RST_TICKS = 100000,
   parameter int SETTLE_TICKS = 200,
   parameter int RDY_TIMEOUT  = 64,
   parameter int PWR_ON_EN    = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            tick,
   input  logic [NCLK-1:0] clk_rdy,
   output logic            phy_test_pd,
   output logic            ref_clk_en,
   output logic            ltssm_en,
   output logic            ep_rst_n,
   output logic            pwr_on,
   output logic [NCLK-1:0] clk_en,
   output logic [3:0]      cfg_dev_type,
   output logic [5:0]      cfg_los_lvl,
   output logic [5:0]      cfg_deemph_g1,
   output logic [5:0]      cfg_deemph_g2a,
   output logic [5:0]      cfg_deemph_g2b,
   output logic [6:0]      cfg_swing_full,
   output logic [6:0]      cfg_swing_low,
   output logic            done,
   output logic            pass
);
   localparam int LIMMAX = imax(EP_RST_TICKS, imax(SETTLE_TICKS, RDY_TIMEOUT));
   localparam int TW     = $clog2(LIMMAX + 1);
   localparam int IW     = (NCLK > 1) ? $clog2(NCLK) : 1;
   localparam logic [IW-1:0] LAST = IW'(NCLK - 1);

   if (NCLK < 1) begin : g_bad_nclk
      $error("NCLK must be at least 1");
   end
   if (EP_RST_TICKS < 1 || SETTLE_TICKS < 1 || RDY_TIMEOUT < 1) begin : g_bad_wait
      $error("every wait must be at least one tick");
   end
   if (PWR_ON_EN != 0 && PWR_ON_EN != 1) begin : g_bad_pwr
      $error("PWR_ON_EN must be 0 or 1");
   end

   prst_state_e   st, nxt;
   logic [IW-1:0] idx, idx_n;
   logic [TW-1:0] lim;
   logic          hit, tmr_clr, adv;
   logic          set_en, drop_en, drop_all, rdy_sel;
   logic [IW-1:0] set_idx;

   logic pd_q, ref_q, ltssm_q, eprst_q, pwr_q, cfg_q, done_q, pass_q;

   always_comb begin
      case (st)
         S_ENTRY:  lim = TW'(EP_RST_TICKS);
         S_SETTLE: lim = TW'(SETTLE_TICKS);
         default:  lim = TW'(RDY_TIMEOUT);
      endcase
   end

   prst_timer #(.TW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (tick),
      .limit (lim),
      .hit   (hit)
   );

   prst_clk_chain #(.N(NCLK), .IW(IW)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_en),
      .set_idx  (set_idx),
      .drop     (drop_en),
      .drop_idx (idx),
      .drop_all (drop_all),
      .sel_idx  (idx),
      .rdy      (clk_rdy),
      .en       (clk_en),
      .rdy_sel  (rdy_sel)
   );

   always_comb begin
      nxt      = st;
      idx_n    = idx;
      adv      = 1'b0;
      set_en   = 1'b0;
      set_idx  = '0;
      drop_en  = 1'b0;
      drop_all = 1'b0;
      case (st)
         S_IDLE:   if (start) nxt = S_ENTRY;
         S_DONE:   if (start) begin
                      nxt      = S_ENTRY;
                      drop_all = 1'b1;
                   end
         S_ENTRY:  if (hit) nxt = S_PHYCFG;
         S_PHYCFG: nxt = S_PWRUP;
         S_PWRUP:  nxt = S_REFON;
         S_REFON:  begin
                      nxt     = S_CLKUP;
                      set_en  = 1'b1;
                      set_idx = '0;
                      idx_n   = '0;
                   end
         S_CLKUP:  begin
                      if (rdy_sel) begin
                         if (idx == LAST) begin
                            nxt = S_SETTLE;
                         end else begin
                            adv     = 1'b1;
                            set_en  = 1'b1;
                            set_idx = idx + 1'b1;
                            idx_n   = idx + 1'b1;
                         end
                      end else if (hit) begin
                         nxt = S_UNWIND;
                      end
                   end
         S_UNWIND: begin
                      drop_en = 1'b1;
                      if (idx == '0) nxt = S_DONE;
                      else           idx_n = idx - 1'b1;
                   end
         S_SETTLE: if (hit) nxt = S_DONE;
         default:  nxt = S_IDLE;
      endcase
   end

   assign tmr_clr = (nxt != st) || adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         idx     <= '0;
         pd_q    <= 1'b1;
         ref_q   <= 1'b0;
         ltssm_q <= 1'b0;
         eprst_q <= 1'b0;
         pwr_q   <= 1'b0;
         cfg_q   <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         st  <= nxt;
         idx <= idx_n;
         if (nxt != st) begin
            case (nxt)
               S_ENTRY: begin
                  pd_q    <= 1'b1;
                  ref_q   <= 1'b0;
                  ltssm_q <= 1'b1;
                  eprst_q <= 1'b0;
                  pwr_q   <= 1'b0;
                  cfg_q   <= 1'b0;
                  done_q  <= 1'b0;
                  pass_q  <= 1'b0;
               end
               S_PHYCFG: begin
                  eprst_q <= 1'b1;
                  ltssm_q <= 1'b0;
                  cfg_q   <= 1'b1;
               end
               S_PWRUP:  pwr_q <= (PWR_ON_EN != 0);
               S_REFON: begin
                  pd_q  <= 1'b0;
                  ref_q <= 1'b1;
               end
               S_DONE: begin
                  done_q  <= 1'b1;
                  pass_q  <= (st == S_SETTLE);
                  ltssm_q <= (st == S_SETTLE);
               end
               default: ;
            endcase
         end
      end
   end

   assign phy_test_pd    = pd_q;
   assign ref_clk_en     = ref_q;
   assign ltssm_en       = ltssm_q;
   assign ep_rst_n       = eprst_q;
   assign pwr_on         = pwr_q;
   assign done           = done_q;
   assign pass           = pass_q;
   assign cfg_dev_type   = cfg_q ? CFG_DEV_ROOT : '0;
   assign cfg_los_lvl    = cfg_q ? CFG_LOS      : '0;
   assign cfg_deemph_g1  = cfg_q ? CFG_DE_G1    : '0;
   assign cfg_deemph_g2a = cfg_q ? CFG_DE_G2A   : '0;
   assign cfg_deemph_g2b = cfg_q ? CFG_DE_G2B   : '0;
   assign cfg_swing_full = cfg_q ? CFG_SW_FULL  : '0;
   assign cfg_swing_low  = cfg_q ? CFG_SW_LOW   : '0;

endmodule

// File: rtl/prst_chk.sv
module prst_chk #(
   parameter int NCLK = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            phy_test_pd,
   input logic            ref_clk_en,
   input logic            ltssm_en,
   input logic            ep_rst_n,
   input logic [NCLK-1:0] clk_en,
   input logic [3:0]      cfg_dev_type,
   input logic [5:0]      cfg_los_lvl,
   input logic            done,
   input logic            pass
);
   logic [NCLK:0] en_p1;
   assign en_p1 = {1'b0, clk_en} + {{NCLK{1'b0}}, 1'b1};

   // R2: without a tick the endpoint reset pulse cannot end
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ltssm_en && !ep_rst_n && !tick) |=> (ltssm_en && !ep_rst_n));

   // R3: release comes with link training off and constants present
   a_r3_release_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_rst_n) |-> (!ltssm_en && cfg_dev_type == 4'd4 && cfg_los_lvl == 6'd9));

   // R4: power-down leaves together with the reference clock arriving
   a_r4_pd_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_test_pd) |-> ($rose(ref_clk_en) && clk_en == '0));

   // R5: enables always form a contiguous mask from bit 0
   a_r5_contig: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_p1[NCLK-1:0] & clk_en) == '0));

   // R7: a passing finish has training on and every clock enabled
   a_r7_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && pass) |-> (ltssm_en && (&clk_en)));

   // R8: a failing finish has nothing enabled
   a_r8_fail_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !pass) |-> (clk_en == '0 && !ltssm_en));

   // R8: withdrawal drops one enable per cycle
   a_r8_unwind_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(done) && ($countones(clk_en) < $countones($past(clk_en))))
         |-> ($countones(clk_en) + 1 == $countones($past(clk_en))));
endmodule

bind pcie_rst_seq prst_chk #(.NCLK(NCLK)) u_prst_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .phy_test_pd  (phy_test_pd),
   .ref_clk_en   (ref_clk_en),
   .ltssm_en     (ltssm_en),
   .ep_rst_n     (ep_rst_n),
   .clk_en       (clk_en),
   .cfg_dev_type (cfg_dev_type),
   .cfg_los_lvl  (cfg_los_lvl),
   .done         (done),
   .pass         (pass)
);

// File: tb/tb_pcie_rst_seq.sv
module tb_pcie_rst_seq;
   localparam int NC  = 4;
   localparam int EP  = 5;
   localparam int SET = 4;
   localparam int RDY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic tick = 1'b0;
   logic [NC-1:0] clk_rdy = '0;

   logic pd, refe, ltssm, eprst, pwr, done, pass;
   logic [NC-1:0] en;
   logic [3:0] c_dev;
   logic [5:0] c_los, c_g1, c_g2a, c_g2b;
   logic [6:0] c_swf, c_swl;

   logic n_pd, n_ref, n_ltssm, n_eprst, n_pwr, n_done, n_pass;
   logic [NC-1:0] n_en;
   logic [3:0] n_dev;
   logic [5:0] n_los, n_g1, n_g2a, n_g2b;
   logic [6:0] n_swf, n_swl;

   int nchk = 0;
   int nbad = 0;
   int ncyc = 0;

   always #4 clk = ~clk;

   pcie_rst_seq #(.NCLK(NC), .EP_RST_TICKS(EP), .SETTLE_TICKS(SET),
                  .RDY_TIMEOUT(RDY), .PWR_ON_EN(1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .clk_rdy(clk_rdy),
      .phy_test_pd(pd), .ref_clk_en(refe), .ltssm_en(ltssm), .ep_rst_n(eprst),
      .pwr_on(pwr), .clk_en(en), .cfg_dev_type(c_dev), .cfg_los_lvl(c_los),
      .cfg_deemph_g1(c_g1), .cfg_deemph_g2a(c_g2a), .cfg_deemph_g2b(c_g2b),
      .cfg_swing_full(c_swf), .cfg_swing_low(c_swl), .done(done), .pass(pass));

   pcie_rst_seq #(.NCLK(NC), .EP_RST_TICKS(EP), .SETTLE_TICKS(SET),
                  .RDY_TIMEOUT(RDY), .PWR_ON_EN(0)) dut_np (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .clk_rdy(clk_rdy),
      .phy_test_pd(n_pd), .ref_clk_en(n_ref), .ltssm_en(n_ltssm), .ep_rst_n(n_eprst),
      .pwr_on(n_pwr), .clk_en(n_en), .cfg_dev_type(n_dev), .cfg_los_lvl(n_los),
      .cfg_deemph_g1(n_g1), .cfg_deemph_g2a(n_g2a), .cfg_deemph_g2b(n_g2b),
      .cfg_swing_full(n_swf), .cfg_swing_low(n_swl), .done(n_done), .pass(n_pass));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pc(input logic [NC-1:0] v);
      int c = 0;
      for (int i = 0; i < NC; i++) if (v[i]) c++;
      return c;
   endfunction

   always @(posedge clk) begin
      ncyc++;
      if (ncyc > 150000) begin
         nbad++;
         nchk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", ncyc, 150000);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   task automatic run(input int p, input int d0, input int d1, input int d2,
                      input int d3, input bit poke);
      int d[NC];
      int seen[NC];
      int entry_t = 0, settle_t = 0, wc = 0, wprev = -1;
      int t_pwr = -1, t_pd = -1, t_ref = -1, t_en0 = -1, t_rel = -1;
      int maxpc = 0, fidx = -1, k = 0;
      bit pred_fail = 0, contig_ok = 1, order_ok = 1, step_ok = 1, np_pwr = 0;
      bit rel_ok = 1, first_ok = 1, poked_wait = 0, fin = 0;
      logic [NC-1:0] prev_en;
      logic prev_done;
      logic [NC-1:0] rnext;
      logic tnext;
      int w, h;
      d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
      for (int i = 0; i < NC; i++) seen[i] = 0;
      @(negedge clk);
      prev_en = en;
      prev_done = done;
      start = 1'b1;
      tick = 1'b0;
      while (!fin) begin
         @(negedge clk);
         start = 1'b0;
         // observation of outputs after the last edge
         if (k == 0) begin
            first_ok = ltssm && pd && !refe && !eprst && !done && !pass && !pwr &&
                       en == '0 && c_dev == 0 && c_los == 0 && c_g2b == 0 && c_swf == 0;
         end
         if (pwr && t_pwr < 0) t_pwr = k;
         if (!pd && t_pd < 0) t_pd = k;
         if (refe && t_ref < 0) t_ref = k;
         if (en[0] && t_en0 < 0) t_en0 = k;
         if (n_pwr) np_pwr = 1;
         if (eprst && t_rel < 0) begin
            t_rel = k;
            rel_ok = !ltssm && c_dev == 4'd4 && c_los == 6'd9 && c_g1 == 6'd0 &&
                     c_g2a == 6'd0 && c_g2b == 6'd20 && c_swf == 7'd127 && c_swl == 7'd127;
         end
         if (t_rel < 0 && (c_dev != 0 || c_los != 0 || c_g2b != 0 || c_swf != 0 || c_swl != 0))
            rel_ok = 0;
         if (((en + 1'b1) & en) != '0) contig_ok = 0;
         for (int i = 1; i < NC; i++)
            if (en[i] && !prev_en[i] && !clk_rdy[i-1]) order_ok = 0;
         if (!prev_done && pc(en) < pc(prev_en) && pc(prev_en) - pc(en) != 1) step_ok = 0;
         if (pc(en) > maxpc) maxpc = pc(en);
         if (done) begin
            fin = 1;
         end else begin
            // stimulus for the next edge
            tnext = ((k % p) == 0);
            for (int i = 0; i < NC; i++) begin
               if (en[i]) begin
                  seen[i]++;
                  rnext[i] = (seen[i] >= d[i]);
               end else begin
                  seen[i] = 0;
                  rnext[i] = 1'b0;
               end
            end
            // reference of the ready timeout
            w = -1;
            h = -1;
            for (int i = 0; i < NC; i++) if (en[i]) h = i;
            if (h >= 0 && !clk_rdy[h] && !pred_fail) w = h;
            if (w != wprev) wc = 0;
            wprev = w;
            if (w >= 0 && !rnext[w] && tnext) begin
               wc++;
               if (wc == RDY) begin
                  pred_fail = 1;
                  fidx = w;
               end
            end
            if (tnext && ltssm && !eprst) entry_t++;
            if (tnext && (&en) && (&clk_rdy) && !ltssm && !done) settle_t++;
            clk_rdy = rnext;
            tick = tnext;
            if (poke && k == 2) start = 1'b1;
            if (poke && w >= 0 && !poked_wait) begin
               start = 1'b1;
               poked_wait = 1;
            end
            prev_en = en;
            prev_done = done;
            k++;
            if (k > 400) begin
               chk(0, "R7 sequence never finished", k, 400);
               fin = 1;
            end
         end
      end
      chk(first_ok, "R2/R9 entry values after start", int'(ltssm), 1);
      chk(entry_t == EP, "R2 endpoint reset length in ticks", entry_t, EP);
      chk(rel_ok, "R3 release values and cfg constants", int'(c_g2b), 20);
      chk(t_pwr >= 0 && t_pwr < t_pd, "R4 power-on before power-down release", t_pwr, t_pd);
      chk(t_pd == t_ref && t_en0 > t_pd, "R4 pd/ref together before clk_en[0]", t_ref, t_pd);
      chk(!np_pwr, "R4 pwr_on held low when option off", int'(np_pwr), 0);
      chk(contig_ok && order_ok, "R5 enable order and contiguity", int'(order_ok), 1);
      chk(pass == !pred_fail, "R6 pass/fail against timeout", int'(pass), int'(!pred_fail));
      chk(n_done && n_pass == pass, "R4 copy without power-on agrees", int'(n_pass), int'(pass));
      if (!pred_fail) begin
         chk(settle_t == SET, "R7 settle length in ticks", settle_t, SET);
         chk(ltssm && en == '1, "R7 training on with all clocks", int'(en), 15);
      end else begin
         chk(en == '0 && !ltssm, "R8 nothing enabled after failure", int'(en), 0);
         chk(maxpc == fidx + 1 && step_ok, "R8 unwind from failed index", maxpc, fidx + 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pd && !refe && !ltssm && !eprst && !pwr && en == '0 && !done && !pass &&
          c_dev == 0 && c_los == 0 && c_g1 == 0 && c_g2a == 0 && c_g2b == 0 &&
          c_swf == 0 && c_swl == 0, "R1 reset state", int'(pd), 1);
      for (int p = 1; p <= 3; p++) begin
         run(p, 1, 1, 1, 1, 0);
         run(p, 2, 1, 3, 2, 1);
         run(p, 99, 1, 1, 1, 0);
         run(p, 1, 2, 1, 99, 1);
         run(p, 3, 4, 5, 6, 0);
         run(p, 2 * p + 1, 3 * p, 3 * p + 1, 1, 1);
      end
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule